// File: doc/BRIEF.md
# Per-Channel Edge Pairing Hit Buffer

This block sits behind the fine-time decoder of one timing channel. Each clock cycle it may receive one decoded discriminator edge: a valid strobe, the edge polarity (rising or falling) and a time stamp counted against the common reference clock. A two-bit mode setting picks what gets stored. The block can keep rising edges only, falling edges only, every edge as its own record, or one record per pulse. A pulse record joins a rising edge with the falling edge that follows it. It carries the rising-edge time and the pulse width, so that later processing can correct for amplitude-dependent time walk.

The width is the falling time minus the rising time, taken modulo the time-stamp range, so pulses that straddle a counter rollover still measure correctly. Widths too large for the width field are clamped to its maximum value. Edges that cannot be paired become error records. A falling edge with no open rising edge can instead be dropped silently, under a configuration bit. Records enter a private first-in first-out store for this channel, which a downstream arbiter drains through a simple read port. When that store is full, new records are thrown away. A sticky flag and a saturating counter report the loss.

Top module: `edge_pair_chan`

## Requirements
- R1: With cfg_mode = 0 (rising only), each rising edge yields one record with tag 0, time field equal to its time stamp and width field 0. Falling edges yield nothing.
- R2: With cfg_mode = 1 (falling only), each falling edge yields one record with tag 1, time field equal to its time stamp and width field 0. Rising edges yield nothing.
- R3: With cfg_mode = 2 (separate edges), every edge yields a record in arrival order. The tag is 0 for rising and 1 for falling, the time field is the time stamp and the width field is 0.
- R4: With cfg_mode = 3 (pairing), a rising edge is held open and yields nothing. The next falling edge then yields a tag 2 record with time field equal to the rising time and width equal to (falling − rising) mod 2^TS_W. Leaving pairing mode discards any open rising edge.
- R5: In pairing mode a width above 2^WID_W − 1 is stored as 2^WID_W − 1.
- R6: In pairing mode a falling edge with no open rising edge yields a tag 3 record with time field equal to its own time stamp and width 0 when cfg_drop_orphan = 0. It yields nothing when cfg_drop_orphan = 1.
- R7: In pairing mode a rising edge that arrives while another is open yields a tag 3 record with the earlier rising time and width field 1. The new rising edge becomes the open one.
- R8: A record word is {tag[1:0], width[WID_W-1:0], time[TS_W-1:0]}, with the tag in the two most significant bits.
- R9: The store holds DEPTH records in order. rd_en while not empty gives rd_vld with the oldest record one cycle later. rd_en while empty gives no rd_vld.
- R10: A record that arrives while full is asserted is discarded. It sets ovf_flag, which stays set until reset, and it raises ovf_count by one, saturating at its maximum.
- R11: After reset, empty = 1, full = 0, ovf_flag = 0, ovf_count = 0 and rd_vld = 0. No rising edge is open.
- R12: An edge sampled at clock edge k lowers empty after clock edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0 rising only, 1 falling only, 2 separate edges, 3 pairing |
| cfg_drop_orphan | input | 1 | Drop unmatched falling edges instead of writing an error record |
| edge_vld | input | 1 | Edge strobe, one edge per cycle |
| edge_rise | input | 1 | 1 rising edge, 0 falling edge |
| edge_ts | input | TS_W | Edge time stamp |
| rd_en | input | 1 | Read request from the arbiter |
| rd_vld | output | 1 | rd_data holds a record this cycle |
| rd_data | output | 2+WID_W+TS_W | Record word |
| empty | output | 1 | Store holds no record |
| full | output | 1 | Store holds DEPTH records |
| ovf_flag | output | 1 | Sticky record-loss flag |
| ovf_count | output | OVF_W | Saturating count of lost records |

## Verification
The bench builds the block with TS_W = 8, WID_W = 4, DEPTH = 8 and OVF_W = 4. An 8-bit time stamp makes rollover across the counter easy to reach with a single pulse, and a 4-bit width field makes clamping occur at a width of 16. A depth of 8 fills the store after a short burst, and a 4-bit loss counter reaches its saturation value within one burst. Random mode changes combined with random edge sequences exercise the carry of an open rising edge between bursts and the clearing of that open edge.

// File: rtl/edgepair_pkg.sv
package edgepair_pkg;
  typedef enum logic [1:0] {
    MODE_LEAD  = 2'd0,
    MODE_TRAIL = 2'd1,
    MODE_BOTH  = 2'd2,
    MODE_PAIR  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    TAG_LEAD  = 2'd0,
    TAG_TRAIL = 2'd1,
    TAG_PAIR  = 2'd2,
    TAG_ERR   = 2'd3
  } tag_e;
endpackage

// File: rtl/edge_pairer.sv
module edge_pairer
  import edgepair_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int WID_W = 12,
  localparam int REC_W = 2 + WID_W + TS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             drop_orphan,
  input  logic             edge_vld,
  input  logic             edge_rise,
  input  logic [TS_W-1:0]  edge_ts,
  output logic             rec_vld,
  output logic [REC_W-1:0] rec_word
);
  logic              pend_vld, nxt_pend_vld;
  logic [TS_W-1:0]   pend_ts, nxt_pend_ts;
  logic              nxt_vld;
  tag_e              nxt_tag;
  logic [WID_W-1:0]  nxt_wid, sat_wid;
  logic [TS_W-1:0]   nxt_time, raw_diff;
  mode_e             md;

  assign md       = mode_e'(mode);
  assign raw_diff = edge_ts - pend_ts;

  generate
    if (TS_W > WID_W) begin : g_clamp
      assign sat_wid = (|raw_diff[TS_W-1:WID_W]) ? {WID_W{1'b1}} : raw_diff[WID_W-1:0];
    end else begin : g_fit
      assign sat_wid = WID_W'(raw_diff);
    end
  endgenerate

  always_comb begin
    nxt_vld      = 1'b0;
    nxt_tag      = TAG_LEAD;
    nxt_wid      = '0;
    nxt_time     = edge_ts;
    nxt_pend_vld = (md == MODE_PAIR) ? pend_vld : 1'b0;
    nxt_pend_ts  = pend_ts;
    if (edge_vld) begin
      case (md)
        MODE_LEAD: begin
          nxt_vld = edge_rise;
          nxt_tag = TAG_LEAD;
        end
        MODE_TRAIL: begin
          nxt_vld = !edge_rise;
          nxt_tag = TAG_TRAIL;
        end
        MODE_BOTH: begin
          nxt_vld = 1'b1;
          nxt_tag = edge_rise ? TAG_LEAD : TAG_TRAIL;
        end
        default: begin
          if (edge_rise) begin
            if (pend_vld) begin
              nxt_vld  = 1'b1;
              nxt_tag  = TAG_ERR;
              nxt_time = pend_ts;
              nxt_wid  = WID_W'(1);
            end
            nxt_pend_vld = 1'b1;
            nxt_pend_ts  = edge_ts;
          end else if (pend_vld) begin
            nxt_vld      = 1'b1;
            nxt_tag      = TAG_PAIR;
            nxt_time     = pend_ts;
            nxt_wid      = sat_wid;
            nxt_pend_vld = 1'b0;
          end else if (!drop_orphan) begin
            nxt_vld = 1'b1;
            nxt_tag = TAG_ERR;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_vld  <= 1'b0;
      rec_word <= '0;
      pend_vld <= 1'b0;
      pend_ts  <= '0;
    end else begin
      rec_vld  <= nxt_vld;
      rec_word <= {nxt_tag, nxt_wid, nxt_time};
      pend_vld <= nxt_pend_vld;
      pend_ts  <= nxt_pend_ts;
    end
  end

  AST_LEAD_IGNORES_FALL: assert property (@(posedge clk) disable iff (rst)
    (edge_vld && !edge_rise && md == MODE_LEAD) |=> !rec_vld); // R1
  AST_TRAIL_IGNORES_RISE: assert property (@(posedge clk) disable iff (rst)
    (edge_vld && edge_rise && md == MODE_TRAIL) |=> !rec_vld); // R2
  AST_RISE_OPENS_PULSE: assert property (@(posedge clk) disable iff (rst)
    (edge_vld && edge_rise && md == MODE_PAIR && !pend_vld) |=> (!rec_vld && pend_vld)); // R4
  AST_ORPHAN_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (edge_vld && !edge_rise && md == MODE_PAIR && !pend_vld && drop_orphan) |=> !rec_vld); // R6
endmodule

// File: rtl/hit_fifo.sv
module hit_fifo #(
  parameter int DATA_W = 30,
  parameter int DEPTH  = 512,
  parameter int OVF_W  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_vld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic              rd_vld,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic              ovf_flag,
  output logic [OVF_W-1:0]  ovf_count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              wr_ok, rd_ok;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign wr_ok = wr_vld && !full;
  assign rd_ok = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      rd_vld    <= 1'b0;
      ovf_flag  <= 1'b0;
      ovf_count <= '0;
    end else begin
      rd_vld <= rd_ok;
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(wr_ok) - CW'(rd_ok);
      if (wr_vld && full) begin
        ovf_flag <= 1'b1;
        if (ovf_count != '1) ovf_count <= ovf_count + 1'b1;
      end
    end
  end

  AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> !rd_vld); // R9
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && !full && !rd_en) |=> (count == $past(count) + 1'b1)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag); // R10
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (wr_vld && full && !rd_en) |=> (ovf_flag && full)); // R10
endmodule

// File: rtl/edge_pair_chan.sv
module edge_pair_chan #(
  parameter int TS_W  = 16,
  parameter int WID_W = 12,
  parameter int DEPTH = 512,
  parameter int OVF_W = 16,
  localparam int REC_W = 2 + WID_W + TS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_drop_orphan,
  input  logic             edge_vld,
  input  logic             edge_rise,
  input  logic [TS_W-1:0]  edge_ts,
  input  logic             rd_en,
  output logic             rd_vld,
  output logic [REC_W-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             ovf_flag,
  output logic [OVF_W-1:0] ovf_count
);
  logic             rec_vld;
  logic [REC_W-1:0] rec_word;

  edge_pairer #(.TS_W(TS_W), .WID_W(WID_W)) u_pairer (
    .clk         (clk),
    .rst         (rst),
    .mode        (cfg_mode),
    .drop_orphan (cfg_drop_orphan),
    .edge_vld    (edge_vld),
    .edge_rise   (edge_rise),
    .edge_ts     (edge_ts),
    .rec_vld     (rec_vld),
    .rec_word    (rec_word)
  );

  hit_fifo #(.DATA_W(REC_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .wr_vld    (rec_vld),
    .wr_data   (rec_word),
    .rd_en     (rd_en),
    .rd_vld    (rd_vld),
    .rd_data   (rd_data),
    .empty     (empty),
    .full      (full),
    .ovf_flag  (ovf_flag),
    .ovf_count (ovf_count)
  );

  AST_EDGE_REACHES_STORE: assert property (@(posedge clk) disable iff (rst)
    (rec_vld && !full && !rd_en) |=> !empty); // R12
endmodule

// File: tb/test_edge_pair_chan.sv
module test_edge_pair_chan;
  localparam int TS_W  = 8;
  localparam int WID_W = 4;
  localparam int DEPTH = 8;
  localparam int OVF_W = 4;
  localparam int REC_W = 2 + WID_W + TS_W;

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       cfg_mode;
  logic             cfg_drop_orphan;
  logic             edge_vld, edge_rise;
  logic [TS_W-1:0]  edge_ts;
  logic             rd_en;
  logic             rd_vld;
  logic [REC_W-1:0] rd_data;
  logic             empty, full, ovf_flag;
  logic [OVF_W-1:0] ovf_count;

  edge_pair_chan #(.TS_W(TS_W), .WID_W(WID_W), .DEPTH(DEPTH), .OVF_W(OVF_W)) i_edge_pair_chan (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_drop_orphan(cfg_drop_orphan),
    .edge_vld(edge_vld), .edge_rise(edge_rise), .edge_ts(edge_ts), .rd_en(rd_en),
    .rd_vld(rd_vld), .rd_data(rd_data), .empty(empty), .full(full),
    .ovf_flag(ovf_flag), .ovf_count(ovf_count)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [REC_W-1:0] q[$];
  bit              m_pend;
  logic [TS_W-1:0] m_pts;
  int              m_ovf;
  bit              m_ovf_flag;
  int              m_mode;
  bit              m_drop;

  function automatic logic [REC_W-1:0] mkw(int tag, int wid, logic [TS_W-1:0] ts);
    return {2'(tag), WID_W'(wid), ts};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_rec(logic [REC_W-1:0] w);
    if (q.size() < DEPTH) q.push_back(w);
    else begin
      m_ovf_flag = 1'b1;
      if (m_ovf < (1 << OVF_W) - 1) m_ovf++;
    end
  endtask

  task automatic model_edge(bit rise, logic [TS_W-1:0] ts);
    logic [TS_W-1:0] d;
    case (m_mode)
      0: if (rise) push_rec(mkw(0, 0, ts));
      1: if (!rise) push_rec(mkw(1, 0, ts));
      2: push_rec(mkw(rise ? 0 : 1, 0, ts));
      default: begin
        if (rise) begin
          if (m_pend) push_rec(mkw(3, 1, m_pts));
          m_pend = 1'b1;
          m_pts  = ts;
        end else if (m_pend) begin
          d = ts - m_pts;
          push_rec(mkw(2, (d > TS_W'((1 << WID_W) - 1)) ? (1 << WID_W) - 1 : int'(d), m_pts));
          m_pend = 1'b0;
        end else if (!m_drop) push_rec(mkw(3, 0, ts));
      end
    endcase
  endtask

  task automatic set_cfg(int mode, bit drop);
    cfg_mode        = 2'(mode);
    cfg_drop_orphan = drop;
    m_mode = mode;
    m_drop = drop;
    if (mode != 3) m_pend = 1'b0;
    @(negedge clk);
  endtask

  task automatic drive_edge(bit rise, logic [TS_W-1:0] ts);
    edge_vld  = 1'b1;
    edge_rise = rise;
    edge_ts   = ts;
    model_edge(rise, ts);
    @(negedge clk);
    edge_vld = 1'b0;
  endtask

  task automatic drain(string req);
    repeat (2) @(negedge clk);
    while (q.size() > 0) begin
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      check(req, 32'(rd_vld), 32'd1);
      check(req, 32'(rd_data), 32'(q.pop_front()));
    end
    check("R9", 32'(empty), 32'd1);
    check("R10", 32'(ovf_flag), 32'(m_ovf_flag));
    check("R10", 32'(ovf_count), 32'(m_ovf));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; edge_vld = 1'b0; edge_rise = 1'b0; edge_ts = '0; rd_en = 1'b0;
    cfg_mode = 2'd0; cfg_drop_orphan = 1'b0;
    m_pend = 1'b0; m_pts = '0; m_ovf = 0; m_ovf_flag = 1'b0; m_mode = 0; m_drop = 1'b0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check("R11", 32'(empty), 32'd1);
    check("R11", 32'(full), 32'd0);
    check("R11", 32'(ovf_flag), 32'd0);
    check("R11", 32'(ovf_count), 32'd0);
    check("R11", 32'(rd_vld), 32'd0);

    // R12: latency into the store
    set_cfg(0, 1'b0);
    drive_edge(1'b1, 8'd5);
    check("R12", 32'(empty), 32'd1);
    @(negedge clk);
    check("R12", 32'(empty), 32'd0);
    // R1: rising only
    drive_edge(1'b0, 8'd9);
    drive_edge(1'b1, 8'd20);
    drain("R1");

    // R2: falling only
    set_cfg(1, 1'b0);
    drive_edge(1'b1, 8'd3);
    drive_edge(1'b0, 8'd7);
    drive_edge(1'b0, 8'd200);
    drain("R2");

    // R3: separate edges in order
    set_cfg(2, 1'b0);
    drive_edge(1'b0, 8'd1);
    drive_edge(1'b1, 8'd2);
    drive_edge(1'b1, 8'd3);
    drive_edge(1'b0, 8'd4);
    drain("R3");

    // R4: pairing, including rollover
    set_cfg(3, 1'b0);
    drive_edge(1'b1, 8'd250);
    drive_edge(1'b0, 8'd5);
    drive_edge(1'b1, 8'd10);
    drive_edge(1'b0, 8'd14);
    drain("R4");

    // R5: width clamp
    drive_edge(1'b1, 8'd10);
    drive_edge(1'b0, 8'd100);
    drain("R5");

    // R6: orphan falling edge, recorded then dropped
    drive_edge(1'b0, 8'd30);
    set_cfg(3, 1'b1);
    drive_edge(1'b0, 8'd40);
    drain("R6");

    // R7: second rising edge before falling
    set_cfg(3, 1'b0);
    drive_edge(1'b1, 8'd50);
    drive_edge(1'b1, 8'd60);
    drive_edge(1'b0, 8'd63);
    drain("R7");

    // R8: explicit word layout
    drive_edge(1'b1, 8'h12);
    drive_edge(1'b0, 8'h15);
    repeat (2) @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R8", 32'(rd_data), 32'h2312);
    void'(q.pop_front());

    // R9: read on empty
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R9", 32'(rd_vld), 32'd0);

    // R10: overflow with counter saturation
    set_cfg(0, 1'b0);
    for (int i = 0; i < DEPTH + 20; i++) drive_edge(1'b1, 8'(i));
    repeat (2) @(negedge clk);
    check("R10", 32'(full), 32'd1);
    check("R10", 32'(ovf_count), 32'd15);
    drain("R10");

    // random rounds
    for (int r = 0; r < 40; r++) begin
      int mode;
      string tagname;
      mode = int'($urandom_range(0, 3));
      set_cfg(mode, 1'($urandom_range(0, 1)));
      for (int e = 0; e < int'($urandom_range(1, 7)); e++) begin
        drive_edge(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
        repeat ($urandom_range(0, 2)) @(negedge clk);
      end
      tagname = (mode == 0) ? "R1" : (mode == 1) ? "R2" : (mode == 2) ? "R3" : "R4";
      drain(tagname);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule